// File: doc/BRIEF.md
# Sound CPU I/O Page Decoder with Boot-ROM Overlay

This block sits between a sound processor's 64 KB address bus and everything that bus can reach. Most addresses go straight through to an external RAM array. The sixteen addresses 00F0h to 00FFh form an I/O page. That page holds a configuration register, an indirect window into a DSP register file, four host mailbox bytes, two spare RAM bytes, and the register slots of three timers. A small boot ROM can shadow the highest addresses of memory. While the ROM is shadowing them, a read returns the ROM byte but a write still lands in the RAM underneath. Clearing the overlay then exposes whatever the CPU stored there.

The CPU presents an address, write data and single-cycle read or write strobes, and it takes read data combinationally in the same cycle. The RAM array and the DSP register file are also read combinationally. Timer period writes, counter reads and counter writes go out to the timer block as one-cycle strobes with a 2-bit timer index. The timer block clears its counter when it sees the read strobe. A host-side load port fills the four mailbox bytes that the CPU reads. CPU writes to the same four addresses fill a separate set of bytes that are driven out to the host.

Top module: `sndio_decoder`

## Requirements
- R1: Addresses 0000h-00EFh and 0100h-FFBFh read the RAM data, and a CPU write there asserts the RAM write enable with the CPU address and data.
- R2: A write to 00F2h loads the DSP index, and a read of 00F2h returns it. A read of 00F3h returns the DSP register whose address is bits 6:0 of the index.
- R3: A write to 00F3h writes the DSP register addressed by index bits 6:0 when index bit 7 is 0. When index bit 7 is 1 the write is dropped, and no DSP write enable is raised.
- R4: While the overlay is enabled, reads of the top ROM_BYTES addresses (FFC0h-FFFFh by default) return the ROM image, in which FFFEh holds C0h and FFFFh holds FFh.
- R5: Writes to the ROM region always assert the RAM write enable. With the overlay disabled, reads there return RAM data, including bytes written while the overlay was enabled.
- R6: Writing 00F1h sets the overlay enable from data bit 7 and the timer enables from data bits 2:0. After reset the overlay is enabled and the timer enables are 000.
- R7: A write to 00F1h with data bit 4 set zeroes mailbox bytes 00F4h/00F5h, and with bit 5 set zeroes 00F6h/00F7h. A host load of a cleared byte in the same cycle loses to the clear.
- R8: 00F8h and 00F9h behave as plain RAM for both reads and writes.
- R9: Reads of 00F0h, 00F1h and 00FAh-00FCh return 00h. Writes to 00F0h-00F7h and 00FAh-00FFh never assert the RAM write enable.
- R10: A write to 00FAh-00FCh raises the period strobe for one cycle, with index address-FAh and the CPU data. A read of 00FDh-00FFh raises the counter-read strobe, with index address-FDh, and returns {0000b, counter}. A write to 00FDh-00FFh raises the counter-clear strobe.
- R11: Reads of 00F4h-00F7h return the host-loaded mailbox bytes. CPU writes to those addresses update the byte (address-F4h) of the to-host output, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| ram_addr | output | 16 | RAM array address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data (combinational) |
| dsp_addr | output | 7 | DSP register address |
| dsp_we | output | 1 | DSP register write enable |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| tmr_idx | output | 2 | Timer index for the timer strobes |
| tmr_period_we | output | 1 | Timer period write strobe |
| tmr_wdata | output | 8 | Timer period value |
| tmr_cnt_rd | output | 1 | Counter read strobe (timer clears on it) |
| tmr_cnt_clr | output | 1 | Counter clear strobe |
| tmr_cnt_data | input | 4 | Counter value of the indexed timer |
| timer_enable | output | 3 | Per-timer enables |
| host_we | input | 1 | Host mailbox load strobe |
| host_sel | input | 2 | Host mailbox byte select |
| host_data | input | 8 | Host mailbox load data |
| to_host_ports | output | 32 | CPU-written mailbox bytes, byte n at bits 8n+7:8n |

## Verification
The assertions assume that read and write strobes are never raised together, that each strobe lasts one cycle per access, and that the DSP index register is the only source of the DSP address. The stimulus raises at most one CPU strobe per cycle. It draws addresses from the low page, the I/O page and the top page, so that every decode branch is reached. Host loads are mixed in randomly, sometimes in the same cycle as a configuration write that clears the mailboxes, and the expected result of that collision follows R7.

// File: rtl/sndio_decoder.sv
module sndio_decoder #(
  parameter int ROM_BYTES = 64,
  parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE = {8'hFF, 8'hC0, {(ROM_BYTES-2)*8{1'b0}}}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  output logic [15:0] ram_addr,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata,
  output logic [6:0]  dsp_addr,
  output logic        dsp_we,
  output logic [7:0]  dsp_wdata,
  input  logic [7:0]  dsp_rdata,
  output logic [1:0]  tmr_idx,
  output logic        tmr_period_we,
  output logic [7:0]  tmr_wdata,
  output logic        tmr_cnt_rd,
  output logic        tmr_cnt_clr,
  input  logic [3:0]  tmr_cnt_data,
  output logic [2:0]  timer_enable,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [7:0]  host_data,
  output logic [31:0] to_host_ports
);
  localparam int ROM_AW = $clog2(ROM_BYTES);
  localparam logic [15:0] ROM_BASE = 16'(32'h10000 - ROM_BYTES);

  logic       rom_en_q;
  logic [2:0] timer_en_q;
  logic [7:0] dsp_idx_q;
  logic [3:0][7:0] port_in_q;
  logic [3:0][7:0] port_out_q;

  wire        io_page  = cpu_addr[15:4] == 12'h00F;
  wire [3:0]  reg_sel  = cpu_addr[3:0];
  wire        in_rom   = cpu_addr >= ROM_BASE;
  wire        spare    = reg_sel == 4'h8 || reg_sel == 4'h9;
  wire        is_tper  = io_page && (reg_sel >= 4'hA) && (reg_sel <= 4'hC);
  wire        is_tcnt  = io_page && (reg_sel >= 4'hD);
  wire        wr_io    = cpu_wr && io_page;
  wire        cfg_wr   = wr_io && reg_sel == 4'h1;
  wire [3:0]  clr_port = {{2{cfg_wr && cpu_wdata[5]}}, {2{cfg_wr && cpu_wdata[4]}}};
  wire [7:0]  rom_byte = ROM_IMAGE[{cpu_addr[ROM_AW-1:0], 3'b000} +: 8];

  assign ram_addr      = cpu_addr;
  assign ram_wdata     = cpu_wdata;
  assign ram_we        = cpu_wr && (!io_page || spare);
  assign dsp_addr      = dsp_idx_q[6:0];
  assign dsp_wdata     = cpu_wdata;
  assign dsp_we        = wr_io && reg_sel == 4'h3 && !dsp_idx_q[7];
  assign tmr_idx       = is_tcnt ? 2'(reg_sel - 4'hD) : 2'(reg_sel - 4'hA);
  assign tmr_wdata     = cpu_wdata;
  assign tmr_period_we = cpu_wr && is_tper;
  assign tmr_cnt_rd    = cpu_rd && is_tcnt;
  assign tmr_cnt_clr   = cpu_wr && is_tcnt;
  assign timer_enable  = timer_en_q;
  assign to_host_ports = port_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_en_q   <= 1'b1;
      timer_en_q <= '0;
      dsp_idx_q  <= '0;
      port_in_q  <= '0;
      port_out_q <= '0;
    end else begin
      if (cfg_wr) begin
        rom_en_q   <= cpu_wdata[7];
        timer_en_q <= cpu_wdata[2:0];
      end
      if (wr_io && reg_sel == 4'h2) dsp_idx_q <= cpu_wdata;
      if (wr_io && reg_sel[3:2] == 2'b01) port_out_q[reg_sel[1:0]] <= cpu_wdata;
      for (int i = 0; i < 4; i++) begin
        if (clr_port[i]) port_in_q[i] <= '0;
        else if (host_we && host_sel == 2'(i)) port_in_q[i] <= host_data;
      end
    end
  end

  always_comb begin
    cpu_rdata = ram_rdata;
    if (io_page) begin
      case (reg_sel)
        4'h2:                   cpu_rdata = dsp_idx_q;
        4'h3:                   cpu_rdata = dsp_rdata;
        4'h4, 4'h5, 4'h6, 4'h7: cpu_rdata = port_in_q[reg_sel[1:0]];
        4'h8, 4'h9:             cpu_rdata = ram_rdata;
        4'hD, 4'hE, 4'hF:       cpu_rdata = {4'h0, tmr_cnt_data};
        default:                cpu_rdata = 8'h00;
      endcase
    end else if (in_rom && rom_en_q) begin
      cpu_rdata = rom_byte;
    end
  end

  p_dsp_hi_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F3 && dsp_idx_q[7]) |-> !dsp_we);
  p_rom_wr_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_rom) |-> (ram_we && ram_addr == cpu_addr && ram_wdata == cpu_wdata));
  p_overlay_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_wr && cpu_addr == 16'h00F1 && !cpu_wdata[7]) && cpu_rd && in_rom)
      |-> cpu_rdata == ram_rdata);
  p_cfg_timers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1) |=> timer_enable == $past(cpu_wdata[2:0]));
  p_clear_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h00F1 && cpu_wdata[4]) |=> (port_in_q[0] == 8'h00 && port_in_q[1] == 8'h00));
  p_io_no_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && io_page && !spare) |-> !ram_we);
  p_one_tmr_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_period_we, tmr_cnt_rd, tmr_cnt_clr}));
endmodule

// File: tb/test_sndio_decoder.sv
`timescale 1ns/1ps
module test_sndio_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [6:0]  dsp_addr;
  logic        dsp_we;
  logic [7:0]  dsp_wdata, dsp_rdata;
  logic [1:0]  tmr_idx;
  logic        tmr_period_we, tmr_cnt_rd, tmr_cnt_clr;
  logic [7:0]  tmr_wdata;
  logic [3:0]  tmr_cnt_data;
  logic [2:0]  timer_enable;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_data = '0;
  logic [31:0] to_host_ports;

  logic [7:0] env_ram [0:511];
  logic [7:0] env_dsp [0:127];
  logic [3:0] env_cnt [0:3];
  logic [7:0] ref_ram [0:511];
  logic [7:0] ref_dsp [0:127];
  logic [7:0] ref_pin [0:3];
  logic [7:0] ref_pout [0:3];
  logic       ref_rom;
  logic [2:0] ref_ten;
  logic [7:0] ref_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign ram_rdata    = env_ram[{ram_addr[15], ram_addr[7:0]}];
  assign dsp_rdata    = env_dsp[dsp_addr];
  assign tmr_cnt_data = env_cnt[tmr_idx];
  always @(posedge clk) begin
    if (ram_we) env_ram[{ram_addr[15], ram_addr[7:0]}] <= ram_wdata;
    if (dsp_we) env_dsp[dsp_addr] <= dsp_wdata;
  end

  sndio_decoder i_sndio_decoder (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ram_tgt(logic [15:0] a);
    return a < 16'h00F0 || a == 16'h00F8 || a == 16'h00F9 || a >= 16'h0100;
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (a >= 16'hFFC0 && ref_rom) return a == 16'hFFFE ? 8'hC0 : (a == 16'hFFFF ? 8'hFF : 8'h00);
    if (ram_tgt(a)) return ref_ram[{a[15], a[7:0]}];
    case (a[3:0])
      4'h2: return ref_idx;
      4'h3: return ref_dsp[ref_idx[6:0]];
      4'h4, 4'h5, 4'h6, 4'h7: return ref_pin[a[1:0]];
      4'hD, 4'hE, 4'hF: return {4'h0, env_cnt[2'(a[3:0] - 4'hD)]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic acc(bit wr, bit rd, logic [15:0] a, logic [7:0] d,
                     bit hw = 0, logic [1:0] hs = 0, logic [7:0] hd = 0);
    logic [7:0] er;
    bit tper, tcr, tcc;
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    host_we = hw; host_sel = hs; host_data = hd;
    #1;
    er   = exp_rd(a);
    tper = wr && a >= 16'h00FA && a <= 16'h00FC;
    tcr  = rd && a >= 16'h00FD && a <= 16'h00FF;
    tcc  = wr && a >= 16'h00FD && a <= 16'h00FF;
    if (rd) chk(a >= 16'hFFC0 ? "R4/R5 read" : (a[15:4] == 12'h00F ? "R2/R8/R9/R10/R11 read" : "R1 read"),
                cpu_rdata, er);
    chk("R1/R5/R9 ram_we", ram_we, wr && ram_tgt(a));
    chk("R3 dsp_we", dsp_we, wr && a == 16'h00F3 && !ref_idx[7]);
    chk("R10 strobes", {tmr_period_we, tmr_cnt_rd, tmr_cnt_clr}, {tper, tcr, tcc});
    if (tper || tcr || tcc)
      chk("R10 index/data", {tmr_idx, tmr_wdata}, {tper ? 2'(a[3:0] - 4'hA) : 2'(a[3:0] - 4'hD), d});
    @(posedge clk);
    if (hw) ref_pin[hs] = hd;
    if (wr) begin
      if (ram_tgt(a)) ref_ram[{a[15], a[7:0]}] = d;
      else case (a[3:0])
        4'h1: begin
          ref_rom = d[7]; ref_ten = d[2:0];
          if (d[4]) begin ref_pin[0] = 0; ref_pin[1] = 0; end
          if (d[5]) begin ref_pin[2] = 0; ref_pin[3] = 0; end
        end
        4'h2: ref_idx = d;
        4'h3: if (!ref_idx[7]) ref_dsp[ref_idx[6:0]] = d;
        4'h4, 4'h5, 4'h6, 4'h7: ref_pout[a[1:0]] = d;
        default: ;
      endcase
    end
    #1;
    if (wr && a == 16'h00F1) chk("R6 timer_enable", timer_enable, ref_ten);
    if (wr && a[15:2] == 14'h003D)
      chk("R11 to_host", to_host_ports, {ref_pout[3], ref_pout[2], ref_pout[1], ref_pout[0]});
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom_range(0, 3))
      0: return 16'($urandom_range(0, 16'h00EF));
      1, 2: return 16'h00F0 | 16'($urandom_range(0, 15));
      default: return 16'hFF00 | 16'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 512; i++) begin env_ram[i] = 8'($urandom); ref_ram[i] = env_ram[i]; end
    for (int i = 0; i < 128; i++) begin env_dsp[i] = 8'($urandom); ref_dsp[i] = env_dsp[i]; end
    for (int i = 0; i < 4; i++) begin env_cnt[i] = 4'($urandom); ref_pin[i] = 0; ref_pout[i] = 0; end
    ref_rom = 1; ref_ten = 0; ref_idx = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset timer_enable", timer_enable, 3'b000);
    chk("R11 reset to_host", to_host_ports, 32'h0);
    // R4 reset vector through the overlay
    acc(0, 1, 16'hFFFE, 0);
    acc(0, 1, 16'hFFFF, 0);
    // R5 write under the overlay, then expose it
    acc(1, 0, 16'hFFC5, 8'h5A);
    acc(0, 1, 16'hFFC5, 0);
    acc(1, 0, 16'h00F1, 8'h05);
    acc(0, 1, 16'hFFC5, 0);
    acc(1, 0, 16'h00F1, 8'h80);
    // R3 high-half index drops the write; R2 masked read
    acc(1, 0, 16'h00F2, 8'h85);
    acc(1, 0, 16'h00F3, 8'hEE);
    acc(0, 1, 16'h00F3, 0);
    acc(0, 1, 16'h00F2, 0);
    // R7 clear beats a same-cycle host load
    acc(0, 0, 16'h0000, 0, 1, 2'd1, 8'h77);
    acc(0, 0, 16'h0000, 0, 1, 2'd2, 8'h66);
    acc(1, 0, 16'h00F1, 8'h90, 1, 2'd0, 8'h33);
    acc(0, 1, 16'h00F4, 0);
    acc(0, 1, 16'h00F5, 0);
    acc(0, 1, 16'h00F6, 0);
    // R8 spare bytes, R10 counters
    acc(1, 0, 16'h00F8, 8'hA1);
    acc(0, 1, 16'h00F8, 0);
    acc(0, 1, 16'h00FE, 0);
    acc(1, 0, 16'h00FB, 8'h10);
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      int op;
      a  = pick_addr();
      op = $urandom_range(0, 2);
      env_cnt[$urandom_range(0, 3)] = 4'($urandom);
      acc(op == 0, op == 1, a, 8'($urandom), $urandom_range(0, 3) == 0,
          2'($urandom), 8'($urandom));
    end
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; host_we = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule